// File: doc/BRIEF.md
# Dual-Issue Dispatch and Completion Tracker

This block tracks instructions through the in-order front and back ends of a small two-wide core. Fetched instructions wait in a six-slot instruction queue. Each clock, up to two of them leave from the two oldest slots toward abstract execution units. Each dispatched instruction takes an entry in a five-slot completion queue and the rename registers it asks for. Finish pulses arrive by completion tag, in any order. Up to two finished entries retire per clock, strictly oldest first. Retirement returns their completion slots and renames.

Each instruction is a 13-bit side-band word. No decode takes place. The word carries an identifier, an execution-unit code, an integer rename demand of 0, 1 or 2, and a floating-point rename demand of 0 or 1. A demand of 2 models a load that also updates its base address register. The surrounding pipeline reads the dispatch lanes, the issued tags and the retire lanes. It also reads the free rename counts.

Top module: `dual_issue_tracker`

## Requirements
- R1: The instruction queue holds six entries. `fetch_room` equals the smaller of 2 and the number of free slots at the start of the cycle. Lane 0 of `fetch_word` (bits 12:0) is accepted when `fetch_vld[0]` is set and the room is at least 1. Lane 1 (bits 25:13) is accepted only together with lane 0 and only when the room is 2. Accepted words are placed behind all older entries, lane 0 first. The word layout is: id in bits 12:5, unit code in bits 4:3, integer demand in bits 2:1, floating-point demand in bit 0.
- R2: Only the two oldest entries can dispatch, on lanes 0 and 1 in that order. Lane 1 never dispatches unless lane 0 does.
- R3: An entry dispatches only if `unit_rdy` is set for its unit code. When both candidates carry the same unit code, the younger one stays in the queue.
- R4: The completion queue holds five entries, and occupancy is counted at the start of the cycle. One dispatch needs one free slot, and a pair needs two. Tags are handed out cyclically 0,1,2,3,4,0,…, starting from 0 after reset. Lane 0 receives the earlier tag.
- R5: A finish pulse on `fin_vld[k]` marks the entry named by tag lane k, starting the next cycle. Lane 0 of `ret_vld` retires the oldest entry when it is finished. Lane 1 retires the next entry only if lane 0 retires and that entry is finished. Entries retire in dispatch order.
- R6: There are five integer renames and four floating-point renames. Dispatch requires the demand to fit the free counts held at the start of the cycle. For a pair, the sum of both demands must fit, or the younger entry is held.
- R7: An entry with integer demand 2 takes two integer renames. Renames go back to the pool on retire and are counted in `int_free` and `fp_free` from the next cycle. When nothing dispatches or retires, both counts hold their value.
- R8: After a synchronous active-low reset, both queues are empty. `fetch_room` is 2, nothing dispatches or retires, `int_free` is 5 and `fp_free` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 2 | Fetch lane valid bits |
| fetch_word | input | 26 | Two instruction words, lane 0 in the low half |
| fetch_room | output | 2 | Number of words that can be accepted this cycle |
| unit_rdy | input | 4 | Ready flag for each execution-unit code |
| disp_vld | output | 2 | Dispatch lane valid bits |
| disp_id | output | 16 | Identifiers of the dispatching entries |
| disp_tag | output | 6 | Completion tags given to the dispatching entries |
| fin_vld | input | 2 | Finish pulse valid bits |
| fin_tag | input | 6 | Completion tags of the finishing entries |
| ret_vld | output | 2 | Retire lane valid bits |
| ret_id | output | 16 | Identifiers of the retiring entries |
| int_free | output | 3 | Free integer renames |
| fp_free | output | 3 | Free floating-point renames |

## Verification
The directed part goes after several corner cases.
- A queue filled while every unit is stalled. A wrong room count here overwrites or drops entries.
- A run of instructions on one unit. A design that ignores unit conflicts dispatches two of them per clock.
- Pairs that each need two integer renames. If allocation checks each lane separately, the pool is over-allocated and `int_free` wraps.
- A completion queue that stops finishing until it is full. A wrong full check hands out a sixth tag that aliases a live entry.

Random traffic with out-of-order finish pulses then compares every lane, tag and free count against a bench model each cycle. A retire path that skips an unfinished head shows up as a mismatch in retire order.

// File: rtl/dit_pkg.sv
// Shared types for the dual-issue tracker.
// Assumes: instruction word layout {id, unit, int demand, fp demand}.
package dit_pkg;
    localparam int ID_W   = 8;
    localparam int UNIT_W = 2;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [UNIT_W-1:0] unit;
        logic [1:0]        ireq;
        logic              freq;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/dit_iq.sv
// Instruction queue: a compacting shift queue, slot 0 is the oldest.
// Assumes: pop_n never exceeds cnt, and push_n never exceeds the free slots.
module dit_iq
    import dit_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_n,
    input  instr_t        push0,
    input  instr_t        push1,
    input  logic [1:0]    pop_n,
    output instr_t        head0,
    output instr_t        head1,
    output logic [CW-1:0] cnt
);
    instr_t slots [DEPTH];
    instr_t nxt   [DEPTH];

    // Shift out the popped entries and append the pushed ones behind the survivors.
    always_comb begin
        int keep;
        keep = int'(cnt) - int'(pop_n);
        for (int i = 0; i < DEPTH; i++) begin
            nxt[i] = '0;
            if (i + int'(pop_n) < int'(cnt))
                nxt[i] = slots[IW'(i + int'(pop_n))];
            else if (i == keep && push_n != 2'd0)
                nxt[i] = push0;
            else if (i == keep + 1 && push_n == 2'd2)
                nxt[i] = push1;
        end
    end

    // Register the slots and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
            cnt <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= nxt[i];
            cnt <= cnt - CW'(pop_n) + CW'(push_n);
        end
    end

    assign head0 = slots[0];
    assign head1 = slots[1];
endmodule

// File: rtl/dit_disp.sv
// Dispatch gate: decides which of the two oldest entries leave this cycle.
// Assumes: all counts are the registered start-of-cycle values.
module dit_disp
    import dit_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int CQ_DEPTH  = 5,
    parameter int IQ_CW     = 3,
    parameter int CQ_CW     = 3,
    parameter int INT_CW    = 3,
    parameter int FP_CW     = 3
) (
    input  instr_t                 head0,
    input  instr_t                 head1,
    input  logic [IQ_CW-1:0]       iq_cnt,
    input  logic [CQ_CW-1:0]       cq_cnt,
    input  logic [INT_CW-1:0]      int_free,
    input  logic [FP_CW-1:0]       fp_free,
    input  logic [NUM_UNITS-1:0]   unit_rdy,
    output logic [1:0]             go
);
    // Lane 0 on its own resources; lane 1 on combined demand and a distinct unit.
    always_comb begin
        int room, i0, i01, f0, f01;
        room = CQ_DEPTH - int'(cq_cnt);
        i0   = int'(head0.ireq);
        i01  = i0 + int'(head1.ireq);
        f0   = int'(head0.freq);
        f01  = f0 + int'(head1.freq);
        go[0] = (iq_cnt != '0) && unit_rdy[head0.unit] && (room >= 1)
              && (i0 <= int'(int_free)) && (f0 <= int'(fp_free));
        go[1] = go[0] && (int'(iq_cnt) >= 2) && (head1.unit != head0.unit)
              && unit_rdy[head1.unit] && (room >= 2)
              && (i01 <= int'(int_free)) && (f01 <= int'(fp_free));
    end
endmodule

// File: rtl/dit_cq.sv
// Completion queue: a circular buffer whose slot index is the completion tag.
// Assumes: alloc_n never exceeds the free slots; finish tags name live entries.
module dit_cq
    import dit_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       alloc_n,
    input  instr_t           alloc0,
    input  instr_t           alloc1,
    input  logic [1:0]       fin_vld,
    input  logic [TAG_W-1:0] fin_tag0,
    input  logic [TAG_W-1:0] fin_tag1,
    output logic [TAG_W-1:0] tag0,
    output logic [TAG_W-1:0] tag1,
    output logic [1:0]       ret,
    output logic [ID_W-1:0]  ret_id0,
    output logic [ID_W-1:0]  ret_id1,
    output logic [2:0]       rel_int,
    output logic [2:0]       rel_fp,
    output logic [CW-1:0]    cnt
);
    logic [DEPTH-1:0] ent_v, ent_f;
    instr_t           ent_d [DEPTH];
    logic [TAG_W-1:0] head, head1;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] t);
        return (int'(t) == DEPTH - 1) ? '0 : t + 1'b1;
    endfunction

    assign head1 = bump(head);
    assign tag1  = bump(tag0);

    // Retire the oldest finished entries in order and sum what they give back.
    always_comb begin
        ret[0]  = ent_v[head] && ent_f[head];
        ret[1]  = ret[0] && ent_v[head1] && ent_f[head1];
        ret_id0 = ent_d[head].id;
        ret_id1 = ent_d[head1].id;
        rel_int = (ret[0] ? {1'b0, ent_d[head].ireq} : 3'd0)
                + (ret[1] ? {1'b0, ent_d[head1].ireq} : 3'd0);
        rel_fp  = (ret[0] ? {2'b0, ent_d[head].freq} : 3'd0)
                + (ret[1] ? {2'b0, ent_d[head1].freq} : 3'd0);
    end

    // Update entry flags, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_f <= '0;
            for (int i = 0; i < DEPTH; i++) ent_d[i] <= '0;
            head <= '0;
            tag0 <= '0;
            cnt  <= '0;
        end else begin
            if (fin_vld[0] && int'(fin_tag0) < DEPTH) ent_f[fin_tag0] <= 1'b1;
            if (fin_vld[1] && int'(fin_tag1) < DEPTH) ent_f[fin_tag1] <= 1'b1;
            if (ret[0]) ent_v[head]  <= 1'b0;
            if (ret[1]) ent_v[head1] <= 1'b0;
            if (alloc_n != 2'd0) begin
                ent_v[tag0] <= 1'b1;
                ent_f[tag0] <= 1'b0;
                ent_d[tag0] <= alloc0;
            end
            if (alloc_n == 2'd2) begin
                ent_v[tag1] <= 1'b1;
                ent_f[tag1] <= 1'b0;
                ent_d[tag1] <= alloc1;
            end
            head <= ret[1] ? bump(head1) : (ret[0] ? head1 : head);
            tag0 <= (alloc_n == 2'd2) ? bump(tag1) : ((alloc_n == 2'd1) ? tag1 : tag0);
            cnt  <= cnt - CW'(ret[0]) - CW'(ret[1]) + CW'(alloc_n);
        end
    end
endmodule

// File: rtl/dit_pool.sv
// Rename pool: a free counter, decremented at dispatch and incremented at retire.
// Assumes: take never exceeds the current free count.
module dit_pool #(
    parameter int TOTAL = 5,
    localparam int CW = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    take,
    input  logic [2:0]    give,
    output logic [CW-1:0] free
);
    // Track the number of free renames.
    always_ff @(posedge clk) begin
        if (!rst_n) free <= CW'(TOTAL);
        else        free <= free - CW'(take) + CW'(give);
    end
endmodule

// File: rtl/dual_issue_tracker.sv
// Dual-issue dispatch and completion tracker: instruction queue, dispatch gate,
// completion queue and two rename pools.
// Assumes: fetch lane 1 is only valid with lane 0; finish tags name live,
// unfinished completion entries.
module dual_issue_tracker
    import dit_pkg::*;
#(
    parameter int IQ_DEPTH    = 6,
    parameter int CQ_DEPTH    = 5,
    parameter int INT_RENAMES = 5,
    parameter int FP_RENAMES  = 4,
    localparam int NUM_UNITS = 1 << UNIT_W,
    localparam int TAG_W  = $clog2(CQ_DEPTH),
    localparam int IQ_CW  = $clog2(IQ_DEPTH + 1),
    localparam int CQ_CW  = $clog2(CQ_DEPTH + 1),
    localparam int INT_CW = $clog2(INT_RENAMES + 1),
    localparam int FP_CW  = $clog2(FP_RENAMES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             fetch_vld,
    input  logic [2*INSTR_W-1:0]   fetch_word,
    output logic [1:0]             fetch_room,
    input  logic [NUM_UNITS-1:0]   unit_rdy,
    output logic [1:0]             disp_vld,
    output logic [2*ID_W-1:0]      disp_id,
    output logic [2*TAG_W-1:0]     disp_tag,
    input  logic [1:0]             fin_vld,
    input  logic [2*TAG_W-1:0]     fin_tag,
    output logic [1:0]             ret_vld,
    output logic [2*ID_W-1:0]      ret_id,
    output logic [INT_CW-1:0]      int_free,
    output logic [FP_CW-1:0]       fp_free
);
    instr_t             head0, head1;
    logic [IQ_CW-1:0]   iq_cnt;
    logic [CQ_CW-1:0]   cq_cnt;
    logic [1:0]         go, push_n, pop_n;
    logic [TAG_W-1:0]   tag0, tag1;
    logic [ID_W-1:0]    rid0, rid1;
    logic [2:0]         rel_int, rel_fp, take_int, take_fp;

    // Fetch room from start-of-cycle occupancy, and the accepted count.
    always_comb begin
        int spare;
        spare = IQ_DEPTH - int'(iq_cnt);
        fetch_room = (spare >= 2) ? 2'd2 : 2'(spare);
        push_n = 2'd0;
        if (fetch_vld[0] && fetch_room != 2'd0) begin
            push_n = 2'd1;
            if (fetch_vld[1] && fetch_room == 2'd2) push_n = 2'd2;
        end
    end

    dit_iq #(.DEPTH(IQ_DEPTH)) u_iq (
        .clk(clk), .rst_n(rst_n), .push_n(push_n),
        .push0(instr_t'(fetch_word[INSTR_W-1:0])),
        .push1(instr_t'(fetch_word[2*INSTR_W-1:INSTR_W])),
        .pop_n(pop_n), .head0(head0), .head1(head1), .cnt(iq_cnt)
    );

    dit_disp #(
        .NUM_UNITS(NUM_UNITS), .CQ_DEPTH(CQ_DEPTH), .IQ_CW(IQ_CW),
        .CQ_CW(CQ_CW), .INT_CW(INT_CW), .FP_CW(FP_CW)
    ) u_disp (
        .head0(head0), .head1(head1), .iq_cnt(iq_cnt), .cq_cnt(cq_cnt),
        .int_free(int_free), .fp_free(fp_free), .unit_rdy(unit_rdy), .go(go)
    );

    // Pop count and rename demand of the dispatching lanes.
    always_comb begin
        pop_n    = {1'b0, go[0]} + {1'b0, go[1]};
        take_int = (go[0] ? {1'b0, head0.ireq} : 3'd0) + (go[1] ? {1'b0, head1.ireq} : 3'd0);
        take_fp  = (go[0] ? {2'b0, head0.freq} : 3'd0) + (go[1] ? {2'b0, head1.freq} : 3'd0);
    end

    dit_cq #(.DEPTH(CQ_DEPTH)) u_cq (
        .clk(clk), .rst_n(rst_n), .alloc_n(pop_n), .alloc0(head0), .alloc1(head1),
        .fin_vld(fin_vld), .fin_tag0(fin_tag[TAG_W-1:0]), .fin_tag1(fin_tag[2*TAG_W-1:TAG_W]),
        .tag0(tag0), .tag1(tag1), .ret(ret_vld), .ret_id0(rid0), .ret_id1(rid1),
        .rel_int(rel_int), .rel_fp(rel_fp), .cnt(cq_cnt)
    );

    dit_pool #(.TOTAL(INT_RENAMES)) u_int_pool (
        .clk(clk), .rst_n(rst_n), .take(take_int), .give(rel_int), .free(int_free)
    );

    dit_pool #(.TOTAL(FP_RENAMES)) u_fp_pool (
        .clk(clk), .rst_n(rst_n), .take(take_fp), .give(rel_fp), .free(fp_free)
    );

    assign disp_vld = go;
    assign disp_id  = {head1.id, head0.id};
    assign disp_tag = {tag1, tag0};
    assign ret_id   = {rid1, rid0};
endmodule

// File: rtl/dit_checker.sv
// Property checker for the dual-issue tracker, attached by bind.
// Assumes: it observes the top's ports and queue occupancies.
module dit_checker #(
    parameter int IQ_DEPTH    = 6,
    parameter int CQ_DEPTH    = 5,
    parameter int INT_RENAMES = 5,
    parameter int FP_RENAMES  = 4,
    parameter int UNIT_W      = 2,
    parameter int IQ_CW       = 3,
    parameter int CQ_CW       = 3,
    parameter int INT_CW      = 3,
    parameter int FP_CW       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        fetch_room,
    input logic [1:0]        disp_vld,
    input logic [1:0]        ret_vld,
    input logic [UNIT_W-1:0] hd_unit0,
    input logic [UNIT_W-1:0] hd_unit1,
    input logic [IQ_CW-1:0]  iq_cnt,
    input logic [CQ_CW-1:0]  cq_cnt,
    input logic [INT_CW-1:0] int_free,
    input logic [FP_CW-1:0]  fp_free
);
    p_iq_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(iq_cnt) <= IQ_DEPTH);
    p_full_no_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(iq_cnt) == IQ_DEPTH |-> fetch_room == 2'd0);
    p_lane1_needs_lane0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[1] |-> disp_vld[0]);
    p_unit_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[1] |-> hd_unit0 != hd_unit1);
    p_cq_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cq_cnt) <= CQ_DEPTH);
    p_cq_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cq_cnt) == CQ_DEPTH |-> disp_vld == 2'b00);
    p_retire_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld[1] |-> ret_vld[0]);
    p_int_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(int_free) <= INT_RENAMES);
    p_fp_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fp_free) <= FP_RENAMES);
    p_pool_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld == 2'b00 && ret_vld == 2'b00) |=> ($stable(int_free) && $stable(fp_free)));
endmodule

bind dual_issue_tracker dit_checker #(
    .IQ_DEPTH(IQ_DEPTH), .CQ_DEPTH(CQ_DEPTH), .INT_RENAMES(INT_RENAMES),
    .FP_RENAMES(FP_RENAMES), .UNIT_W(dit_pkg::UNIT_W), .IQ_CW(IQ_CW),
    .CQ_CW(CQ_CW), .INT_CW(INT_CW), .FP_CW(FP_CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_room(fetch_room), .disp_vld(disp_vld),
    .ret_vld(ret_vld), .hd_unit0(head0.unit), .hd_unit1(head1.unit),
    .iq_cnt(iq_cnt), .cq_cnt(cq_cnt), .int_free(int_free), .fp_free(fp_free)
);

// File: tb/dual_issue_tracker_tb.sv
`timescale 1ns/1ps
// Bench: directed corners then seeded random traffic, checked each cycle
// against a model of the instruction queue, completion queue and pools.
module dual_issue_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fetch_vld = '0;
    logic [25:0] fetch_word = '0;
    logic [1:0]  fetch_room;
    logic [3:0]  unit_rdy = '0;
    logic [1:0]  disp_vld;
    logic [15:0] disp_id;
    logic [5:0]  disp_tag;
    logic [1:0]  fin_vld = '0;
    logic [5:0]  fin_tag = '0;
    logic [1:0]  ret_vld;
    logic [15:0] ret_id;
    logic [2:0]  int_free, fp_free;

    always #4 clk = ~clk;

    dual_issue_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
        .fetch_room(fetch_room), .unit_rdy(unit_rdy), .disp_vld(disp_vld),
        .disp_id(disp_id), .disp_tag(disp_tag), .fin_vld(fin_vld), .fin_tag(fin_tag),
        .ret_vld(ret_vld), .ret_id(ret_id), .int_free(int_free), .fp_free(fp_free)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [12:0] m_iq [6];
    logic [12:0] m_cq [5];
    bit   m_v [5];
    bit   m_f [5];
    int   m_iqn = 0, m_hd = 0, m_tl = 0, m_cqn = 0, m_if = 5, m_ff = 4;
    int   g_unit = -1, g_ireq = -1, g_freq = -1;
    logic [7:0] next_id = 8'd1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int f_unit(input logic [12:0] w); return int'(w[4:3]); endfunction
    function automatic int f_ireq(input logic [12:0] w); return int'(w[2:1]); endfunction
    function automatic int f_freq(input logic [12:0] w); return int'(w[0]);   endfunction

    task automatic mk(output logic [12:0] w);
        logic [1:0] u, ir;
        logic fr;
        u  = (g_unit < 0) ? 2'($urandom % 4) : 2'(g_unit);
        ir = (g_ireq < 0) ? 2'($urandom % 3) : 2'(g_ireq);
        fr = (g_freq < 0) ? 1'($urandom % 2) : 1'(g_freq);
        w = {next_id, u, ir, fr};
        next_id = next_id + 8'd1;
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input int nf, input logic [3:0] urdy, input bit fin_en);
        int room, nfin, npop, h1, old_n;
        int ft [2];
        logic [12:0] w0, w1;
        bit g0, g1, r0, r1;
        @(negedge clk);
        room = (6 - m_iqn >= 2) ? 2 : 6 - m_iqn;
        if (nf > room) nf = room;
        mk(w0);
        mk(w1);
        fetch_vld  = (nf == 2) ? 2'b11 : ((nf == 1) ? 2'b01 : 2'b00);
        fetch_word = {w1, w0};
        unit_rdy   = urdy;
        nfin = 0;
        ft[0] = 0;
        ft[1] = 0;
        if (fin_en) begin
            for (int k = 0; k < 5; k++) begin
                int idx;
                idx = (m_hd + k) % 5;
                if (m_v[idx] && !m_f[idx] && nfin < 2 && ($urandom % 2) == 1) begin
                    ft[nfin] = idx;
                    nfin++;
                end
            end
        end
        fin_vld = (nfin == 2) ? 2'b11 : ((nfin == 1) ? 2'b01 : 2'b00);
        fin_tag = {3'(ft[1]), 3'(ft[0])};
        #1;
        g0 = m_iqn >= 1 && urdy[f_unit(m_iq[0])] && m_cqn < 5
             && f_ireq(m_iq[0]) <= m_if && f_freq(m_iq[0]) <= m_ff;
        g1 = g0 && m_iqn >= 2 && f_unit(m_iq[1]) != f_unit(m_iq[0])
             && urdy[f_unit(m_iq[1])] && m_cqn <= 3
             && f_ireq(m_iq[0]) + f_ireq(m_iq[1]) <= m_if
             && f_freq(m_iq[0]) + f_freq(m_iq[1]) <= m_ff;
        h1 = (m_hd + 1) % 5;
        r0 = m_v[m_hd] && m_f[m_hd];
        r1 = r0 && m_v[h1] && m_f[h1];
        chk("R1 fetch_room", int'(fetch_room), room);
        chk("R2 R3 R4 R6 dispatch lanes", int'(disp_vld), int'({g1, g0}));
        if (g0) begin
            chk("R2 lane0 id", int'(disp_id[7:0]), int'(m_iq[0][12:5]));
            chk("R4 lane0 tag", int'(disp_tag[2:0]), m_tl);
        end
        if (g1) begin
            chk("R2 lane1 id", int'(disp_id[15:8]), int'(m_iq[1][12:5]));
            chk("R4 lane1 tag", int'(disp_tag[5:3]), (m_tl + 1) % 5);
        end
        chk("R5 retire lanes", int'(ret_vld), int'({r1, r0}));
        if (r0) chk("R5 retire id lane0", int'(ret_id[7:0]), int'(m_cq[m_hd][12:5]));
        if (r1) chk("R5 retire id lane1", int'(ret_id[15:8]), int'(m_cq[h1][12:5]));
        chk("R6 R7 int_free", int'(int_free), m_if);
        chk("R6 R7 fp_free", int'(fp_free), m_ff);
        // Model update: retire, finish, dispatch, fetch.
        if (r0) begin
            m_v[m_hd] = 0; m_if += f_ireq(m_cq[m_hd]); m_ff += f_freq(m_cq[m_hd]); m_cqn--;
        end
        if (r1) begin
            m_v[h1] = 0; m_if += f_ireq(m_cq[h1]); m_ff += f_freq(m_cq[h1]); m_cqn--;
        end
        m_hd = (m_hd + int'(r0) + int'(r1)) % 5;
        for (int k = 0; k < nfin; k++) m_f[ft[k]] = 1;
        npop = int'(g0) + int'(g1);
        for (int k = 0; k < npop; k++) begin
            m_cq[m_tl] = m_iq[k]; m_v[m_tl] = 1; m_f[m_tl] = 0;
            m_if -= f_ireq(m_iq[k]); m_ff -= f_freq(m_iq[k]);
            m_tl = (m_tl + 1) % 5; m_cqn++;
        end
        old_n = m_iqn;
        for (int i = 0; i < 6; i++) m_iq[i] = (i + npop < old_n) ? m_iq[i + npop] : 13'd0;
        m_iqn = old_n - npop;
        if (nf >= 1) begin m_iq[m_iqn] = w0; m_iqn++; end
        if (nf == 2) begin m_iq[m_iqn] = w1; m_iqn++; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cyc >= 60000);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5; i++) begin m_v[i] = 0; m_f[i] = 0; m_cq[i] = '0; end
        for (int i = 0; i < 6; i++) m_iq[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: state right after reset.
        #1;
        chk("R8 reset fetch_room", int'(fetch_room), 2);
        chk("R8 reset no dispatch", int'(disp_vld), 0);
        chk("R8 reset no retire", int'(ret_vld), 0);
        chk("R8 reset int_free", int'(int_free), 5);
        chk("R8 reset fp_free", int'(fp_free), 4);
        // R1 and R3: every unit stalled while the queue fills to six.
        for (int i = 0; i < 4; i++) step(2, 4'h0, 0);
        // R3: all on one unit, one dispatch per clock.
        g_unit = 1; g_ireq = 0; g_freq = 0;
        for (int i = 0; i < 10; i++) step(2, 4'hF, 1);
        for (int i = 0; i < 20; i++) step(0, 4'hF, 1);
        // R7 and R6: pairs each needing two integer renames.
        g_unit = -1; g_ireq = 2;
        for (int i = 0; i < 6; i++) step(2, 4'hF, 0);
        for (int i = 0; i < 25; i++) step(1, 4'hF, 1);
        // R6: floating-point pool exhaustion.
        g_ireq = 0; g_freq = 1;
        for (int i = 0; i < 6; i++) step(2, 4'hF, 0);
        for (int i = 0; i < 25; i++) step(0, 4'hF, 1);
        // R4: completion queue fills with no finishes.
        g_freq = 0;
        for (int i = 0; i < 8; i++) step(2, 4'hF, 0);
        for (int i = 0; i < 25; i++) step(0, 4'hF, 1);
        // Random traffic with out-of-order finishes.
        g_unit = -1; g_ireq = -1; g_freq = -1;
        for (int i = 0; i < 4000; i++)
            step(int'($urandom % 3), 4'($urandom), ($urandom % 4) != 0);
        // Drain: all renames return (R7) and the queue empties (R1).
        for (int i = 0; i < 80; i++) step(0, 4'hF, 1);
        @(negedge clk);
        #1;
        chk("R7 drained int_free", int'(int_free), 5);
        chk("R7 drained fp_free", int'(fp_free), 4);
        chk("R1 drained fetch_room", int'(fetch_room), 2);
        summary();
        $finish;
    end
endmodule